// File: doc/BRIEF.md
# Serial Line Frame Monitor with Edge-Timing Check

This block listens passively to one asynchronous serial line that carries frames of one low start bit, eight data bits sent least significant bit first, and one high stop bit. It never drives the line. From the line alone it rebuilds every byte and presents it with a one-cycle valid strobe. While it does so it also checks where each level change on the line falls. A change is accepted only when it lies within five percent of either end of a bit period. A start bit that ends early, a level change inside a data bit, or a stop bit that drops in its middle makes the monitor raise a one-cycle error strobe and discard the frame.

After an error the monitor stops listening for two bit periods. This lets the rest of a corrupted frame pass without being read as a new start bit. The bit period, in clock cycles, is derived at elaboration from the clock frequency and the baud rate. The serial input is brought into the clock domain through a two-stage synchronizer whose flops reset high, which is the idle level of the line.

Top module: `uart_line_monitor`

## Requirements
- R1: While reset is held, and afterwards while the line stays high, `byteValid` and `frameError` are both low.
- R2: The bit period P is (CLK_HZ + BAUD_HZ/2) / BAUD_HZ clock cycles, using integer division. A frame in which every bit lasts exactly P cycles is accepted without error.
- R3: Each data bit is sampled when the remaining count of its period equals P/2. The bits are assembled least significant bit first. When a high stop bit runs to the end of its period, `byteValid` is high for one cycle and `byteData` holds the byte during that cycle.
- R4: Let c be the remaining count of the current bit after that cycle's decrement. A level change is legal only when 20·c < P or 20·c > 19·P. With P = 40, a frame edge that arrives one cycle early or one cycle late is accepted, and an edge that arrives two cycles early or two cycles late is an error.
- R5: If the line returns high during the start bit at an illegal position, the result is an error and no byte.
- R6: Any change of the line inside a data bit at an illegal position is an error, and the frame's byte is not delivered.
- R7: During the stop bit, a low level at an illegal position is an error. A low level at a legal position delivers the byte at once, so a frame that follows with no gap is also received.
- R8: An error produces a `frameError` pulse of exactly one cycle and never appears together with `byteValid`. For the next 2·P cycles the line is ignored: a low pulse in that window raises no error and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Monitored serial line, idle high |
| byteValid | output | 1 | One-cycle strobe for a received byte |
| byteData | output | 8 | Received byte, valid while byteValid is high |
| frameError | output | 1 | One-cycle strobe for a framing or timing violation |

## Verification
On every cycle the assertions check the following. Both strobes are single-cycle pulses and are never high together. An error strobe always coincides with the recovery state, and no byte is strobed while the monitor is recovering. The bit-period counter never exceeds two periods, and the bit index never passes eight. Other behaviour can only be shown by the bench's directed scenarios. These are the byte values rebuilt from real frames, the exact width of the legal edge window (edges one cycle off are accepted, edges two cycles off are rejected), the early delivery of a byte on a back-to-back frame, and the way activity during recovery is ignored.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_ERR   = 3'd4
  } monState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBit;     // counter <= one bit period
    logic loadErr;     // counter <= two bit periods
    logic count;       // counter <= counter - 1
    logic clearFrame;  // bit index and byte register cleared
    logic sample;      // store line level in next bit position
  } dpCtrl_t;

endpackage

// File: rtl/uart_mon_datapath.sv
module uart_mon_datapath
  import uart_mon_pkg::*;
#(
  parameter int BIT_CYCLES = 434
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  dpCtrl_t             ctrl,
  output logic                lineNow,
  output logic                lineChanged,
  output logic                atZero,
  output logic                atMid,
  output logic                edgeBad,
  output logic                bitsDone,
  output logic [7:0]          byteReg
);

  localparam int CNT_W    = $clog2(2 * BIT_CYCLES + 1);
  localparam int PROD_W   = CNT_W + 5;
  localparam int HALF     = BIT_CYCLES / 2;
  localparam int HI_LIMIT = 19 * BIT_CYCLES;

  logic [1:0]        syncQ;
  logic              prevLine;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cntNext;
  logic [3:0]        bitIdx;
  logic [PROD_W-1:0] scaled;

  // two-stage synchronizer, resets to idle-high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      prevLine <= 1'b1;
    end else begin
      syncQ    <= {syncQ[0], serialIn};
      prevLine <= syncQ[1];
    end
  end

  assign lineNow     = syncQ[1];
  assign lineChanged = (syncQ[1] != prevLine);

  // decrement first, every check uses the decremented value
  assign cntNext = cnt - CNT_W'(1);
  assign atZero  = (cntNext == '0);
  assign atMid   = (cntNext == CNT_W'(HALF));

  // 5%..95% window without division: P <= 20c <= 19P is illegal
  assign scaled  = PROD_W'(cntNext) * PROD_W'(20);
  assign edgeBad = (scaled >= PROD_W'(BIT_CYCLES)) && (scaled <= PROD_W'(HI_LIMIT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrl.loadErr) begin
      cnt <= CNT_W'(2 * BIT_CYCLES);
    end else if (ctrl.loadBit) begin
      cnt <= CNT_W'(BIT_CYCLES);
    end else if (ctrl.count) begin
      cnt <= cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx  <= '0;
      byteReg <= '0;
    end else if (ctrl.clearFrame) begin
      bitIdx  <= '0;
      byteReg <= '0;
    end else if (ctrl.sample && !bitIdx[3]) begin
      byteReg[bitIdx[2:0]] <= lineNow;
      bitIdx               <= bitIdx + 4'd1;
    end
  end

  assign bitsDone = (bitIdx == 4'd8);

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(2 * BIT_CYCLES))
    else $error("counter above two bit periods");

  p_bit_index_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitIdx <= 4'd8)
    else $error("bit index past eight");

  p_clear_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearFrame |=> (bitIdx == 4'd0 && byteReg == 8'd0))
    else $error("frame not cleared at start");

  p_recovery_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadErr |=> (cnt == CNT_W'(2 * BIT_CYCLES)))
    else $error("recovery count not loaded");

endmodule

// File: rtl/uart_mon_control.sv
module uart_mon_control
  import uart_mon_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineNow,
  input  logic    lineChanged,
  input  logic    atZero,
  input  logic    atMid,
  input  logic    edgeBad,
  input  logic    bitsDone,
  output dpCtrl_t ctrl,
  output logic    byteValid,
  output logic    frameError
);

  monState_t state, stateNext;
  logic      emitNext;
  logic      errNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    emitNext  = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!lineNow) begin
          stateNext       = ST_START;
          ctrl.loadBit    = 1'b1;
          ctrl.clearFrame = 1'b1;
        end
      end
      ST_START: begin
        ctrl.count = 1'b1;
        if (lineNow && edgeBad) begin
          stateNext    = ST_ERR;
          ctrl.loadErr = 1'b1;
          errNext      = 1'b1;
        end else if (atZero) begin
          stateNext    = ST_DATA;
          ctrl.loadBit = 1'b1;
        end
      end
      ST_DATA: begin
        ctrl.count = 1'b1;
        if (lineChanged && edgeBad) begin
          stateNext    = ST_ERR;
          ctrl.loadErr = 1'b1;
          errNext      = 1'b1;
        end else begin
          ctrl.sample = atMid;
          if (atZero) begin
            ctrl.loadBit = 1'b1;
            if (bitsDone) stateNext = ST_STOP;
          end
        end
      end
      ST_STOP: begin
        ctrl.count = 1'b1;
        if (!lineNow) begin
          if (edgeBad) begin
            stateNext    = ST_ERR;
            ctrl.loadErr = 1'b1;
            errNext      = 1'b1;
          end else begin
            stateNext = ST_IDLE;
            emitNext  = 1'b1;
          end
        end else if (atZero) begin
          stateNext = ST_IDLE;
          emitNext  = 1'b1;
        end
      end
      ST_ERR: begin
        ctrl.count = 1'b1;
        if (atZero) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      byteValid  <= 1'b0;
      frameError <= 1'b0;
    end else begin
      state      <= stateNext;
      byteValid  <= emitNext;
      frameError <= errNext;
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid)
    else $error("byte strobe longer than one cycle");

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameError |=> !frameError)
    else $error("error strobe longer than one cycle");

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(byteValid && frameError))
    else $error("byte and error strobes together");

  p_err_recovers_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameError |-> (state == ST_ERR))
    else $error("error strobe outside recovery");

  p_no_emit_recovery_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERR) |-> !byteValid)
    else $error("byte strobed during recovery");

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !frameError)
    else $error("error while idle");

endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor
  import uart_mon_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int BAUD_HZ = 115_200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       frameError
);

  localparam int BIT_CYCLES = (CLK_HZ + BAUD_HZ / 2) / BAUD_HZ;

  dpCtrl_t ctrl;
  logic    lineNow, lineChanged, atZero, atMid, edgeBad, bitsDone;

  uart_mon_datapath #(.BIT_CYCLES(BIT_CYCLES)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .ctrl       (ctrl),
    .lineNow    (lineNow),
    .lineChanged(lineChanged),
    .atZero     (atZero),
    .atMid      (atMid),
    .edgeBad    (edgeBad),
    .bitsDone   (bitsDone),
    .byteReg    (byteData)
  );

  uart_mon_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .lineNow    (lineNow),
    .lineChanged(lineChanged),
    .atZero     (atZero),
    .atMid      (atMid),
    .edgeBad    (edgeBad),
    .bitsDone   (bitsDone),
    .ctrl       (ctrl),
    .byteValid  (byteValid),
    .frameError (frameError)
  );

endmodule

// File: tb/uart_line_monitor_bench.sv
module uart_line_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 2000;
  localparam int BAUD_HZ    = 50;
  localparam int P          = (CLK_HZ + BAUD_HZ / 2) / BAUD_HZ; // 40

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       serialIn = 1'b1;
  logic       byteValid;
  logic [7:0] byteData;
  logic       frameError;

  int compared = 0;
  int mismatched = 0;
  int rxCount = 0;
  int errCount = 0;
  int longPulse = 0;
  logic [7:0] rxLog [0:63];
  logic prevValid = 1'b0;
  logic prevErr = 1'b0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_line_monitor #(.CLK_HZ(CLK_HZ), .BAUD_HZ(BAUD_HZ)) u_uart_line_monitor (
    .clk(clk), .rstN(rstN), .serialIn(serialIn),
    .byteValid(byteValid), .byteData(byteData), .frameError(frameError)
  );

  // observe strobes away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        rxLog[rxCount[5:0]] = byteData;
        rxCount++;
      end
      if (frameError) errCount++;
      if ((byteValid && prevValid) || (frameError && prevErr) || (byteValid && frameError))
        longPulse++;
      prevValid = byteValid;
      prevErr   = frameError;
    end
  end

  task automatic checkEq(input string req, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic hold(input logic level, input int n);
    serialIn = level;
    repeat (n) @(negedge clk);
  endtask

  // one frame; bit stretchIdx lasts P+delta; abort holds high after that bit
  task automatic driveFrame(input logic [7:0] b, input int stretchIdx, input int delta,
                            input bit abort, input int stopLen);
    hold(1'b0, P);
    for (int i = 0; i < 8; i++) begin
      hold(b[i], (i == stretchIdx) ? P + delta : P);
      if (abort && i == stretchIdx) begin
        hold(1'b1, 6 * P);
        return;
      end
    end
    hold(1'b1, stopLen);
  endtask

  task automatic t_reset();
    checkEq("R1 valid during reset", int'(byteValid), 0);
    checkEq("R1 error during reset", int'(frameError), 0);
    @(negedge clk); rstN = 1'b1;
    hold(1'b1, 3 * P);
    checkEq("R1 no bytes while idle", rxCount, 0);
    checkEq("R1 no errors while idle", errCount, 0);
  endtask

  task automatic t_basic();
    logic [7:0] pats [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    for (int k = 0; k < 4; k++) begin
      int r0 = rxCount, e0 = errCount;
      driveFrame(pats[k], -1, 0, 1'b0, P);
      hold(1'b1, 2 * P);
      checkEq("R2 R3 byte count", rxCount - r0, 1);
      checkEq("R3 byte value", int'(rxLog[r0[5:0]]), int'(pats[k]));
      checkEq("R2 no error on exact period", errCount - e0, 0);
    end
  endtask

  task automatic t_window();
    int deltas [4] = '{1, -1, 2, -2};
    for (int k = 0; k < 4; k++) begin
      int r0 = rxCount, e0 = errCount;
      bit bad = (deltas[k] == 2 || deltas[k] == -2);
      driveFrame(8'h55, 3, deltas[k], bad, P);
      hold(1'b1, 3 * P);
      if (bad) begin
        checkEq("R4 R6 edge two cycles off flagged", errCount - e0, 1);
        checkEq("R6 no byte after data violation", rxCount - r0, 0);
      end else begin
        checkEq("R4 edge one cycle off accepted", errCount - e0, 0);
        checkEq("R4 byte count", rxCount - r0, 1);
        checkEq("R4 byte value", int'(rxLog[r0[5:0]]), 8'h55);
      end
    end
  endtask

  task automatic t_dataGlitch();
    int r0 = rxCount, e0 = errCount;
    hold(1'b0, P);
    hold(1'b0, P);
    hold(1'b0, P/2);
    hold(1'b1, 3);
    hold(1'b1, 6 * P);
    checkEq("R6 mid-bit change flagged", errCount - e0, 1);
    checkEq("R6 no byte delivered", rxCount - r0, 0);
  endtask

  task automatic t_startGlitch();
    int r0 = rxCount, e0 = errCount;
    hold(1'b0, 10);
    hold(1'b1, 4 * P);
    checkEq("R5 short start flagged", errCount - e0, 1);
    checkEq("R5 no byte", rxCount - r0, 0);
  endtask

  task automatic t_stopLow();
    int r0 = rxCount, e0 = errCount;
    driveFrame(8'hFF, -1, 0, 1'b0, P/2);
    hold(1'b0, P/2);
    hold(1'b1, 4 * P);
    checkEq("R7 low inside stop flagged", errCount - e0, 1);
    checkEq("R7 no byte on bad stop", rxCount - r0, 0);
  endtask

  task automatic t_backToBack();
    int r0 = rxCount, e0 = errCount;
    driveFrame(8'h12, -1, 0, 1'b0, P);
    driveFrame(8'h34, -1, 0, 1'b0, P);
    hold(1'b1, 2 * P);
    checkEq("R7 both frames received", rxCount - r0, 2);
    checkEq("R7 first byte", int'(rxLog[r0[5:0]]), 8'h12);
    checkEq("R7 second byte", int'(rxLog[(r0 + 1) & 63]), 8'h34);
    checkEq("R7 no error on back-to-back", errCount - e0, 0);
  endtask

  task automatic t_recovery();
    int r0, e0 = errCount;
    hold(1'b0, 10);
    hold(1'b1, 10);
    hold(1'b0, P/2 - 5);
    hold(1'b1, 4 * P);
    checkEq("R8 single error, pulse in recovery ignored", errCount - e0, 1);
    r0 = rxCount;
    driveFrame(8'h81, -1, 0, 1'b0, P);
    hold(1'b1, 2 * P);
    checkEq("R8 receives after recovery", rxCount - r0, 1);
    checkEq("R8 byte after recovery", int'(rxLog[r0[5:0]]), 8'h81);
    checkEq("R8 strobes one cycle and exclusive", longPulse, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_window();
    t_dataGlitch();
    t_startGlitch();
    t_stopLow();
    t_backToBack();
    t_recovery();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule